// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block collects data words from a serial link whose clock comes from an external master. The serial clock and data inputs are brought into the system clock domain through a two-flop synchroniser. The chosen edge of the synchronised clock (rising or falling, set by a polarity input) takes one data bit into a shift register, least significant bit first. A word is 8 bits long, or 9 bits when the wide-word control is set.

When the last bit of a word arrives, the data moves into a holding register, a ready flag goes high and, if the interrupt enable is set, an interrupt request is raised. A read strobe takes the word and clears the flag. The ninth bit and the error flags sit beside the data. If a word completes while the previous one is still unread, the new word is dropped, an overrun flag is set and shifting stops. The overrun is cleared only by dropping the continuous-receive enable.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset, data_out, ninth_bit, rx_flag, irq, ovr_err and frm_err are all 0.
- R2: Bits are taken only while port_en=1, sync_mode=1, clk_src_master=0 and cont_en=1. With clk_src_master=1, serial clock edges leave rx_flag at 0.
- R3: single_en has no effect. With cont_en=0 and single_en=1, a full word leaves rx_flag at 0.
- R4: Bits arrive least significant bit first. After 8 sampled bits (wide_word=0), data_out holds the word, ninth_bit is 0 and rx_flag is 1.
- R5: With wide_word=1, a word is 9 bits. Bits 0..7 appear on data_out and bit 8 appears on ninth_bit.
- R6: With sclk_pol=0, data is sampled on rising serial clock edges. With sclk_pol=1, it is sampled on falling edges.
- R7: irq is 1 exactly when rx_flag=1 and rx_ie=1.
- R8: A one-cycle pulse on rd_data while rx_flag=1 clears rx_flag.
- R9: If a word completes while rx_flag=1, ovr_err is set, data_out keeps the earlier word, and no further words are accepted while ovr_err=1.
- R10: Setting cont_en=0 clears ovr_err and discards any partly received word.
- R11: frm_err is always 0, because a synchronous frame has no stop bit to check.
- R12: rx_flag rises no later than 4 system clocks after the sampling edge of the final bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Selects synchronous operation |
| clk_src_master | input | 1 | 1 = internal clock source (master), 0 = external clock (slave) |
| cont_en | input | 1 | Continuous receive enable; dropping it clears errors |
| single_en | input | 1 | Single-receive enable, ignored in slave mode |
| wide_word | input | 1 | 1 = 9-bit words |
| rx_ie | input | 1 | Receive interrupt enable |
| sclk_pol | input | 1 | 0 = sample on rising edge, 1 = sample on falling edge |
| ser_clk | input | 1 | Serial clock from the external master |
| ser_data | input | 1 | Serial data |
| rd_data | input | 1 | Read strobe for the holding register |
| data_out | output | DW | Received data word |
| ninth_bit | output | 1 | Ninth bit of the last word |
| rx_flag | output | 1 | Word ready |
| irq | output | 1 | Interrupt request |
| ovr_err | output | 1 | Overrun error |
| frm_err | output | 1 | Framing error (always 0) |

## Verification
A wrong bit counter shows up at the ports within one word. Data_out then holds bits shifted by one position, or the flag rises a bit early or late, so every vector in the table compares data_out against the word that was sent. A lost or sticky overrun state shows up on the next word: data_out is overwritten, or the flag does not rise after the enable has been cycled. Because of this, the overrun tests always send a following word. A wrong edge choice or synchroniser depth shows up as a swapped bit pattern or a late flag, which the check 6 system clocks after the last edge catches.

// File: rtl/sync_slave_rx.sv
module sync_slave_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_en,
  input  logic          sync_mode,
  input  logic          clk_src_master,
  input  logic          cont_en,
  input  logic          single_en,
  input  logic          wide_word,
  input  logic          rx_ie,
  input  logic          sclk_pol,
  input  logic          ser_clk,
  input  logic          ser_data,
  input  logic          rd_data,
  output logic [DW-1:0] data_out,
  output logic          ninth_bit,
  output logic          rx_flag,
  output logic          irq,
  output logic          ovr_err,
  output logic          frm_err
);
  localparam int FW = DW + 1;
  localparam int CW = $clog2(FW + 1);

  logic [2:0]    sc_q;
  logic [1:0]    sd_q;
  logic [CW-1:0] cnt_q;
  logic [FW-1:0] sh_q;
  logic [FW-1:0] asm_w;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sc_q <= '0;
      sd_q <= '0;
    end else begin
      sc_q <= {sc_q[1:0], ser_clk};
      sd_q <= {sd_q[0], ser_data};
    end

  wire rise      = sc_q[1] & ~sc_q[2];
  wire fall      = ~sc_q[1] & sc_q[2];
  wire samp      = sclk_pol ? fall : rise;
  wire slave_sel = port_en & sync_mode & ~clk_src_master;
  wire run       = slave_sel & cont_en & ~ovr_err;
  wire take      = run & samp;
  wire [CW-1:0] last = wide_word ? CW'(DW) : CW'(DW - 1);
  wire done      = take & (cnt_q == last);
  wire load      = done & (~rx_flag | rd_data);

  always_comb begin
    asm_w = sh_q;
    asm_w[cnt_q] = sd_q[1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (!slave_sel || !cont_en) begin
      cnt_q <= '0;
    end else if (take) begin
      sh_q  <= done ? '0 : asm_w;
      cnt_q <= done ? '0 : cnt_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      data_out  <= '0;
      ninth_bit <= 1'b0;
      rx_flag   <= 1'b0;
    end else if (load) begin
      data_out  <= asm_w[DW-1:0];
      ninth_bit <= wide_word & asm_w[DW];
      rx_flag   <= 1'b1;
    end else if (rd_data) begin
      rx_flag   <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                ovr_err <= 1'b0;
    else if (!cont_en)         ovr_err <= 1'b0;
    else if (done && !load)    ovr_err <= 1'b1;

  assign irq     = rx_flag & rx_ie;
  assign frm_err = 1'b0;

  // R3
  single_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single_en && !cont_en) |=> !$rose(rx_flag));
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ie |-> !irq);
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && rd_data && !done) |=> !rx_flag);
  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && !rd_data) |=> $stable(data_out));
  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && cont_en) |=> ovr_err);
  // R10
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cont_en |=> !ovr_err);
  // R2
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_sel |=> !$rose(rx_flag));
endmodule

// File: tb/sync_slave_rx_tb.sv
module sync_slave_rx_tb;
  logic clk = 0, rst_n = 0;
  logic port_en = 1, sync_mode = 1, clk_src_master = 0, cont_en = 1, single_en = 0;
  logic wide_word = 0, rx_ie = 1, sclk_pol = 0, ser_clk = 0, ser_data = 0, rd_data = 0;
  logic [7:0] data_out;
  logic ninth_bit, rx_flag, irq, ovr_err, frm_err;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  sync_slave_rx #(.DW(8)) u_dut (.*);

  // {wide_word, sclk_pol, word[8:0]}
  localparam logic [10:0] VEC [0:5] = '{
    {1'b0, 1'b0, 9'h0A5}, {1'b0, 1'b0, 9'h03C}, {1'b0, 1'b1, 9'h0E1},
    {1'b1, 1'b0, 9'h1FF}, {1'b1, 1'b1, 9'h100}, {1'b1, 1'b1, 9'h0F0}};

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pol(input logic p);
    @(negedge clk);
    sclk_pol = p;
    ser_clk = p;
    wait_clk(4);
  endtask

  task automatic send_bits(input logic [8:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      ser_data = w[i];
      wait_clk(4);
      ser_clk = ~sclk_pol;
      wait_clk(4);
      ser_clk = sclk_pol;
    end
    wait_clk(6);
  endtask

  task automatic read_word();
    @(negedge clk);
    rd_data = 1;
    @(negedge clk);
    rd_data = 0;
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait_clk(3);
    // R1 reset state
    check("R1", {data_out, ninth_bit}, 9'h0);
    check("R1", {rx_flag, irq, ovr_err, frm_err}, 9'h0);
    rst_n = 1;
    wait_clk(2);

    foreach (VEC[k]) begin
      wide_word = VEC[k][10];
      set_pol(VEC[k][9]);
      send_bits(VEC[k][8:0], VEC[k][10] ? 9 : 8);
      check("R4/R6 data", {1'b0, data_out}, {1'b0, VEC[k][7:0]});
      check("R5 ninth", {8'h0, ninth_bit}, {8'h0, VEC[k][10] & VEC[k][8]});
      check("R4 flag", {8'h0, rx_flag}, 9'h1);
      check("R11 frm", {8'h0, frm_err}, 9'h0);
      read_word();
      check("R8 clear", {8'h0, rx_flag}, 9'h0);
    end

    wide_word = 0;
    set_pol(0);
    // R7
    rx_ie = 0;
    send_bits(9'h055, 8);
    check("R7 irq off", {7'h0, rx_flag, irq}, 9'h2);
    rx_ie = 1;
    wait_clk(1);
    check("R7 irq on", {8'h0, irq}, 9'h1);
    read_word();
    check("R7 irq drop", {8'h0, irq}, 9'h0);

    // R2
    clk_src_master = 1;
    send_bits(9'h0C3, 8);
    check("R2 master", {8'h0, rx_flag}, 9'h0);
    clk_src_master = 0;

    // R3
    cont_en = 0; single_en = 1;
    send_bits(9'h0C3, 8);
    check("R3 single", {8'h0, rx_flag}, 9'h0);
    cont_en = 1; single_en = 0;
    wait_clk(2);

    // R12 latency: final edge then exactly 4 clocks
    send_bits(9'h012, 7);
    ser_data = 1'b1;
    wait_clk(4);
    ser_clk = 1;
    wait_clk(4);
    check("R12 latency", {8'h0, rx_flag}, 9'h1);
    check("R12 data", {1'b0, data_out}, 9'h092);
    ser_clk = 0;
    read_word();

    // R9
    send_bits(9'h011, 8);
    send_bits(9'h022, 8);
    check("R9 ovr", {8'h0, ovr_err}, 9'h1);
    check("R9 keep", {1'b0, data_out}, 9'h011);
    read_word();
    send_bits(9'h033, 8);
    check("R9 stop", {7'h0, rx_flag, ovr_err}, 9'h1);
    check("R9 keep2", {1'b0, data_out}, 9'h011);

    // R10
    cont_en = 0;
    wait_clk(2);
    check("R10 clear", {8'h0, ovr_err}, 9'h0);
    cont_en = 1;
    send_bits(9'h044, 8);
    check("R10 resume", {1'b0, data_out}, 9'h044);
    read_word();
    send_bits(9'h007, 3);
    cont_en = 0;
    wait_clk(2);
    cont_en = 1;
    send_bits(9'h0B6, 8);
    check("R10 partial", {1'b0, data_out}, 9'h0B6);
    check("R10 flag", {8'h0, rx_flag}, 9'h1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule